// File: doc/BRIEF.md
# Multi-block DMA channel sequencer

This block is the control sequencer of one DMA channel whose transfer is split into several blocks. The data mover reports the end of each block. The descriptor fetch engine reports when the next descriptor has arrived. Between those two handshakes, the sequencer decides how the source and destination addresses are formed for the following block. Each side can restart from its programmed base, run on from where the previous block stopped, or take a fresh address from a fetched descriptor.

The configuration inputs are read at every block end and reduced to a transfer mode row. Rows 1 to 4 have a null link pointer. Row 1 uses no reload, row 2 reloads the source only, row 3 reloads the destination only and row 4 reloads both. Row 5 has a non-null pointer with no list and no reload. Rows 6 to 10 use the descriptor list: row 6 (source runs on, destination from list), row 7 (source reloads, destination from list), row 8 (source from list, destination runs on), row 9 (source from list, destination reloads) and row 10 (both from list). The row chooses one of four outcomes: go straight on, fetch a descriptor, hold for software acknowledgement, or end the transfer. At every block end the block raises a block-complete interrupt when that interrupt is enabled and unmasked. Software drops the interrupt by writing the channel's clear bit, and that same write releases a held channel.

Top module: `mblk_chan_seq`

## Requirements
- R1: From idle, a `chan_go` pulse with a supported configuration makes `blk_go` high for exactly one cycle, in the cycle after the edge that sampled `chan_go`, with `src_sel` and `dst_sel` both 0. `chan_go` has no effect while a transfer is in progress.
- R2: The address selects use three codes: 0 = programmed base (restart or reload), 1 = run on from the end address of the previous block, 2 = address from the fetched descriptor. At each block end that continues the transfer, each side is set for the next block. A side gets 2 when its list enable is set and `link_null` is 0. Otherwise it gets 0 when its reload bit is set, and 1 in all other cases.
- R3: The combination `link_null`=0 with both list enables clear and at least one reload bit set is unsupported. At a start it pulses `cfg_fault` and starts no block. At a block end it pulses `cfg_fault` together with `xfer_end`, and `status_fetch` stays 0. A configuration in which both sides run on and the transfer continues is therefore never reached.
- R4: `blk_irq` goes high at the end of every block (including the last block) when `irq_enable`=1 and `blk_mask`=0. It stays high until a `blk_ack` write clears it. A block end that raises it takes priority over an acknowledgement in the same cycle.
- R5: In rows 6, 8 and 10, `desc_fetch` rises in the cycle after the block end, whatever the interrupt settings. It stays high until `desc_ack`, and `blk_go` pulses in the cycle after `desc_ack`.
- R6: In rows 2, 3, 4, 7 and 9, when the interrupt is enabled and unmasked, the channel holds after the block end. No `blk_go` or `desc_fetch` is issued until a `blk_ack` write.
- R7: In rows 2 to 4, with `irq_enable`=0 or `blk_mask`=1, `blk_go` pulses in the cycle right after the block end.
- R8: When the row sampled at a block end is 1 or 5, `xfer_end` pulses and the channel returns to idle. `status_fetch` pulses together with `xfer_end` only in row 5.
- R9: Rows 2 to 4 keep repeating blocks until software has cleared both reload bits. The reload bits are read only at block ends.
- R10: A `blk_ack` write made while a transfer is in progress but before the hold is entered is remembered. The next hold then lasts one cycle: `blk_go` comes two cycles after the block end. An early acknowledgement does not prevent `blk_irq` from being raised at that block end.
- R11: In rows 7 and 9 with a hold, the descriptor fetch starts in the cycle after the releasing `blk_ack`.
- R12: `rst` is synchronous and active high. While it is applied, all pulse outputs, `desc_fetch` and `blk_irq` are 0, and both selects are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_go | input | 1 | Start pulse for a new transfer |
| src_list_en | input | 1 | Source address taken from descriptors |
| dst_list_en | input | 1 | Destination address taken from descriptors |
| src_reload | input | 1 | Source address restarts from base each block |
| dst_reload | input | 1 | Destination address restarts from base each block |
| link_null | input | 1 | Next-descriptor pointer is zero |
| blk_end | input | 1 | Data mover finished writing a block |
| desc_ack | input | 1 | Descriptor fetch complete |
| irq_enable | input | 1 | Channel interrupt enable |
| blk_mask | input | 1 | Block interrupt mask (1 = masked) |
| blk_ack | input | 1 | Software clear-block write pulse |
| blk_go | output | 1 | Start next block pulse |
| desc_fetch | output | 1 | Request to the descriptor fetch engine |
| src_sel | output | 2 | Source address select for the current block |
| dst_sel | output | 2 | Destination address select for the current block |
| blk_irq | output | 1 | Block-complete interrupt |
| xfer_end | output | 1 | Transfer terminated pulse |
| status_fetch | output | 1 | Fetch status of the last block, with xfer_end |
| cfg_fault | output | 1 | Unsupported configuration pulse |

## Verification
The bench targets several corner cases. The first is the hold in reload rows. A design that ignored the mask or the enable would stall a channel that should run freely, and one that ignored the acknowledgement would never resume. The second is reconfiguration in the middle of a block. It shows whether the reload bits are read only at block ends, so that a design reading them continuously would end or change mode one block early. Further cases cover an acknowledgement written before the hold, which a design that drops it would leave stuck, and mixed rows 7 and 9, where a design that fetched before holding would issue `desc_fetch` too early. The last group contrasts the two ending rows, the unsupported configuration at start and at block end, and the select codes each side receives.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  localparam int ROW_W = 4;
  localparam int SEL_W = 2;

  localparam logic [ROW_W-1:0] ROW_FAULT = ROW_W'(0);
  localparam logic [ROW_W-1:0] ROW_ONE   = ROW_W'(1);
  localparam logic [ROW_W-1:0] ROW_FIVE  = ROW_W'(5);

  typedef enum logic [SEL_W-1:0] {
    ADDR_BASE = 2'd0,
    ADDR_CONT = 2'd1,
    ADDR_DESC = 2'd2
  } addr_sel_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_HOLD  = 2'd2,
    PH_FETCH = 2'd3
  } phase_e;

  typedef struct packed {
    addr_sel_e src;
    addr_sel_e dst;
    logic      fault;
    logic      last;
    logic      wb;
    logic      reload_any;
    logic      list_any;
  } row_info_t;

endpackage

// File: rtl/mbs_row_decode.sv
module mbs_row_decode
  import mbs_pkg::*;
(
  input  logic      src_list_en,
  input  logic      dst_list_en,
  input  logic      src_reload,
  input  logic      dst_reload,
  input  logic      link_null,
  output row_info_t info
);

  logic             list_s;
  logic             list_d;
  logic [ROW_W-1:0] row;

  // a list enable only counts while a next descriptor exists
  assign list_s = src_list_en & ~link_null;
  assign list_d = dst_list_en & ~link_null;

  always_comb begin
    if (link_null) begin
      case ({dst_reload, src_reload})
        2'b00:   row = ROW_W'(1);
        2'b01:   row = ROW_W'(2);
        2'b10:   row = ROW_W'(3);
        default: row = ROW_W'(4);
      endcase
    end else if (!list_s && !list_d) begin
      row = (src_reload | dst_reload) ? ROW_FAULT : ROW_FIVE;
    end else if (list_s && list_d) begin
      row = ROW_W'(10);
    end else if (list_s) begin
      row = dst_reload ? ROW_W'(9) : ROW_W'(8);
    end else begin
      row = src_reload ? ROW_W'(7) : ROW_W'(6);
    end
  end

  always_comb begin
    info.src        = list_s ? ADDR_DESC : (src_reload ? ADDR_BASE : ADDR_CONT);
    info.dst        = list_d ? ADDR_DESC : (dst_reload ? ADDR_BASE : ADDR_CONT);
    info.fault      = (row == ROW_FAULT);
    info.last       = (row == ROW_ONE) || (row == ROW_FIVE);
    info.wb         = (row == ROW_FIVE);
    info.list_any   = list_s | list_d;
    info.reload_any = (!list_s && src_reload) || (!list_d && dst_reload);
  end

endmodule

// File: rtl/mbs_irq_track.sv
module mbs_irq_track (
  input  logic clk,
  input  logic rst,
  input  logic active,
  input  logic set_evt,
  input  logic clr,
  input  logic consume,
  output logic irq,
  output logic pend
);

  // interrupt flag: a new block end wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (set_evt) begin
      irq <= 1'b1;
    end else if (clr) begin
      irq <= 1'b0;
    end
  end

  // remembered acknowledgement, spent when a hold is released
  always_ff @(posedge clk) begin
    if (rst || !active) begin
      pend <= 1'b0;
    end else if (consume) begin
      pend <= 1'b0;
    end else if (clr) begin
      pend <= 1'b1;
    end
  end

  a_r4_irq_holds: assert property (@(posedge clk) disable iff (rst)
    (irq && !clr && !set_evt) |=> irq);

  a_r4_irq_cleared: assert property (@(posedge clk) disable iff (rst)
    (clr && !set_evt) |=> !irq);

  a_r10_ack_kept: assert property (@(posedge clk) disable iff (rst)
    (clr && active && !consume) |=> pend);

endmodule

// File: rtl/mbs_step_fsm.sv
module mbs_step_fsm
  import mbs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      chan_go,
  input  logic      blk_end,
  input  logic      desc_ack,
  input  logic      irq_ok,
  input  logic      release_ok,
  input  row_info_t info,
  output phase_e    phase,
  output logic      blk_go,
  output logic      desc_fetch,
  output addr_sel_e src_sel,
  output addr_sel_e dst_sel,
  output logic      xfer_end,
  output logic      status_fetch,
  output logic      cfg_fault,
  output logic      consume,
  output logic      set_evt
);

  logic need_list;

  assign consume = (phase == PH_HOLD) && release_ok;
  assign set_evt = (phase == PH_RUN) && blk_end && irq_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase        <= PH_IDLE;
      blk_go       <= 1'b0;
      desc_fetch   <= 1'b0;
      src_sel      <= ADDR_BASE;
      dst_sel      <= ADDR_BASE;
      xfer_end     <= 1'b0;
      status_fetch <= 1'b0;
      cfg_fault    <= 1'b0;
      need_list    <= 1'b0;
    end else begin
      blk_go       <= 1'b0;
      xfer_end     <= 1'b0;
      status_fetch <= 1'b0;
      cfg_fault    <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (chan_go) begin
            if (info.fault) begin
              cfg_fault <= 1'b1;
            end else begin
              blk_go  <= 1'b1;
              src_sel <= ADDR_BASE;
              dst_sel <= ADDR_BASE;
              phase   <= PH_RUN;
            end
          end
        end
        PH_RUN: begin
          if (blk_end) begin
            if (info.fault) begin
              cfg_fault <= 1'b1;
              xfer_end  <= 1'b1;
              phase     <= PH_IDLE;
            end else if (info.last) begin
              xfer_end     <= 1'b1;
              status_fetch <= info.wb;
              phase        <= PH_IDLE;
            end else begin
              src_sel   <= info.src;
              dst_sel   <= info.dst;
              need_list <= info.list_any;
              if (info.reload_any && irq_ok) begin
                phase <= PH_HOLD;
              end else if (info.list_any) begin
                desc_fetch <= 1'b1;
                phase      <= PH_FETCH;
              end else begin
                blk_go <= 1'b1;
              end
            end
          end
        end
        PH_HOLD: begin
          if (release_ok) begin
            if (need_list) begin
              desc_fetch <= 1'b1;
              phase      <= PH_FETCH;
            end else begin
              blk_go <= 1'b1;
              phase  <= PH_RUN;
            end
          end
        end
        default: begin
          if (desc_ack) begin
            desc_fetch <= 1'b0;
            blk_go     <= 1'b1;
            phase      <= PH_RUN;
          end
        end
      endcase
    end
  end

  a_r6_hold_blocks: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_HOLD && !release_ok) |=> (!blk_go && !desc_fetch));

  a_r5_fetch_waits: assert property (@(posedge clk) disable iff (rst)
    (desc_fetch && !desc_ack) |=> desc_fetch);

  a_r8_wb_with_end: assert property (@(posedge clk) disable iff (rst)
    status_fetch |-> xfer_end);

  a_r3_fault_quiet: assert property (@(posedge clk) disable iff (rst)
    cfg_fault |-> (!status_fetch && !blk_go));

  a_r8_end_idle: assert property (@(posedge clk) disable iff (rst)
    xfer_end |-> (phase == PH_IDLE));

  a_r1_go_ignored: assert property (@(posedge clk) disable iff (rst)
    (chan_go && phase == PH_HOLD && !release_ok) |=> !blk_go);

endmodule

// File: rtl/mblk_chan_seq.sv
module mblk_chan_seq
  import mbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_go,
  input  logic             src_list_en,
  input  logic             dst_list_en,
  input  logic             src_reload,
  input  logic             dst_reload,
  input  logic             link_null,
  input  logic             blk_end,
  input  logic             desc_ack,
  input  logic             irq_enable,
  input  logic             blk_mask,
  input  logic             blk_ack,
  output logic             blk_go,
  output logic             desc_fetch,
  output logic [SEL_W-1:0] src_sel,
  output logic [SEL_W-1:0] dst_sel,
  output logic             blk_irq,
  output logic             xfer_end,
  output logic             status_fetch,
  output logic             cfg_fault
);

  row_info_t info;
  phase_e    phase;
  addr_sel_e src_e;
  addr_sel_e dst_e;
  logic      irq_ok;
  logic      pend;
  logic      consume;
  logic      set_evt;
  logic      active;

  assign irq_ok  = irq_enable & ~blk_mask;
  assign active  = (phase != PH_IDLE);
  assign src_sel = src_e;
  assign dst_sel = dst_e;

  mbs_row_decode u_decode (
    .src_list_en (src_list_en),
    .dst_list_en (dst_list_en),
    .src_reload  (src_reload),
    .dst_reload  (dst_reload),
    .link_null   (link_null),
    .info        (info)
  );

  mbs_irq_track u_irq (
    .clk     (clk),
    .rst     (rst),
    .active  (active),
    .set_evt (set_evt),
    .clr     (blk_ack),
    .consume (consume),
    .irq     (blk_irq),
    .pend    (pend)
  );

  mbs_step_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .chan_go      (chan_go),
    .blk_end      (blk_end),
    .desc_ack     (desc_ack),
    .irq_ok       (irq_ok),
    .release_ok   (blk_ack | pend),
    .info         (info),
    .phase        (phase),
    .blk_go       (blk_go),
    .desc_fetch   (desc_fetch),
    .src_sel      (src_e),
    .dst_sel      (dst_e),
    .xfer_end     (xfer_end),
    .status_fetch (status_fetch),
    .cfg_fault    (cfg_fault),
    .consume      (consume),
    .set_evt      (set_evt)
  );

  a_r12_reset_quiet: assert property (@(posedge clk)
    rst |=> (!blk_go && !desc_fetch && !blk_irq && !xfer_end && src_sel == 2'd0));

endmodule

// File: tb/test_mblk_chan_seq.sv
`timescale 1ns/1ps
module test_mblk_chan_seq;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chan_go = 0, src_list_en = 0, dst_list_en = 0, src_reload = 0, dst_reload = 0;
  logic link_null = 1, blk_end = 0, desc_ack = 0, irq_enable = 0, blk_mask = 0, blk_ack = 0;
  logic blk_go, desc_fetch, blk_irq, xfer_end, status_fetch, cfg_fault;
  logic [1:0] src_sel, dst_sel;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  mblk_chan_seq i_mblk_chan_seq (
    .clk(clk), .rst(rst), .chan_go(chan_go),
    .src_list_en(src_list_en), .dst_list_en(dst_list_en),
    .src_reload(src_reload), .dst_reload(dst_reload), .link_null(link_null),
    .blk_end(blk_end), .desc_ack(desc_ack), .irq_enable(irq_enable),
    .blk_mask(blk_mask), .blk_ack(blk_ack),
    .blk_go(blk_go), .desc_fetch(desc_fetch), .src_sel(src_sel), .dst_sel(dst_sel),
    .blk_irq(blk_irq), .xfer_end(xfer_end), .status_fetch(status_fetch),
    .cfg_fault(cfg_fault)
  );

  // ---------------- behavioural reference ----------------
  function automatic int mode_row(bit nul, bit ls, bit rs, bit ld, bit rd);
    bit as = ls && !nul;
    bit ad = ld && !nul;
    if (nul) return 1 + int'(rs) + 2 * int'(rd);
    if (!as && !ad) return (rs || rd) ? 0 : 5;
    if (as && ad) return 10;
    if (as) return rd ? 9 : 8;
    return rs ? 7 : 6;
  endfunction

  function automatic int side_code(bit nul, bit l, bit r);
    if (l && !nul) return 2;
    return r ? 0 : 1;
  endfunction

  int m_phase = 0;      // 0 idle, 1 block running, 2 waiting ack, 3 waiting descriptor
  bit m_go, m_fetch, m_irq, m_pend, m_end, m_wb, m_fault, m_after_list;
  int m_ss, m_ds;
  int row, ss, ds;
  bit enabled, rel, reload_row, list_row;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_go = 0; m_fetch = 0; m_irq = 0; m_pend = 0;
      m_end = 0; m_wb = 0; m_fault = 0; m_ss = 0; m_ds = 0; m_after_list = 0;
    end else begin
      row = mode_row(link_null, src_list_en, src_reload, dst_list_en, dst_reload);
      ss = side_code(link_null, src_list_en, src_reload);
      ds = side_code(link_null, dst_list_en, dst_reload);
      enabled = irq_enable && !blk_mask;
      rel = blk_ack || m_pend;
      reload_row = (row == 2 || row == 3 || row == 4 || row == 7 || row == 9);
      list_row = (row >= 6);
      if (m_phase == 1 && blk_end && enabled) m_irq = 1;
      else if (blk_ack) m_irq = 0;
      if (m_phase == 0 || (m_phase == 2 && rel)) m_pend = 0;
      else if (blk_ack) m_pend = 1;
      m_go = 0; m_end = 0; m_wb = 0; m_fault = 0;
      case (m_phase)
        0: if (chan_go) begin
             if (row == 0) m_fault = 1;
             else begin m_go = 1; m_ss = 0; m_ds = 0; m_phase = 1; end
           end
        1: if (blk_end) begin
             if (row == 0) begin m_fault = 1; m_end = 1; m_phase = 0; end
             else if (row == 1 || row == 5) begin m_end = 1; m_wb = (row == 5); m_phase = 0; end
             else begin
               m_ss = ss; m_ds = ds; m_after_list = list_row;
               if (reload_row && enabled) m_phase = 2;
               else if (list_row) begin m_fetch = 1; m_phase = 3; end
               else m_go = 1;
             end
           end
        2: if (rel) begin
             if (m_after_list) begin m_fetch = 1; m_phase = 3; end
             else begin m_go = 1; m_phase = 1; end
           end
        default: if (desc_ack) begin m_fetch = 0; m_go = 1; m_phase = 1; end
      endcase
    end
  end

  task automatic cmp(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cmp("R7 model blk_go", int'(blk_go), int'(m_go));
      cmp("R5 model desc_fetch", int'(desc_fetch), int'(m_fetch));
      cmp("R2 model src_sel", int'(src_sel), m_ss);
      cmp("R2 model dst_sel", int'(dst_sel), m_ds);
      cmp("R4 model blk_irq", int'(blk_irq), int'(m_irq));
      cmp("R8 model xfer_end", int'(xfer_end), int'(m_end));
      cmp("R8 model status_fetch", int'(status_fetch), int'(m_wb));
      cmp("R3 model cfg_fault", int'(cfg_fault), int'(m_fault));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cyc(int n = 1);
    repeat (n) begin @(posedge clk); #2; end
  endtask
  task automatic go();       chan_go = 1;  cyc(); chan_go = 0;  endtask
  task automatic fin();      blk_end = 1;  cyc(); blk_end = 0;  endtask
  task automatic ack();      blk_ack = 1;  cyc(); blk_ack = 0;  endtask
  task automatic dack();     desc_ack = 1; cyc(); desc_ack = 0; endtask
  task automatic cfg(bit nul, bit ls, bit rs, bit ld, bit rd);
    link_null = nul; src_list_en = ls; src_reload = rs; dst_list_en = ld; dst_reload = rd;
  endtask

  initial begin
    #(8 * 50000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(3);
    // R12 reset state
    cmp("R12 blk_go", int'(blk_go), 0);
    cmp("R12 blk_irq", int'(blk_irq), 0);
    cmp("R12 desc_fetch", int'(desc_fetch), 0);
    cmp("R12 src_sel", int'(src_sel), 0);
    rst = 0;
    cyc(2);

    // R1 / R8 single block in row 1
    irq_enable = 1; blk_mask = 0; cfg(1, 0, 0, 0, 0);
    go();
    cmp("R1 blk_go", int'(blk_go), 1);
    cmp("R1 sels", int'({src_sel, dst_sel}), 0);
    cyc();
    cmp("R1 one cycle", int'(blk_go), 0);
    cyc(2); fin();
    cmp("R8 row1 end", int'(xfer_end), 1);
    cmp("R8 row1 no status", int'(status_fetch), 0);
    cmp("R4 irq on last", int'(blk_irq), 1);
    ack();
    cmp("R4 irq cleared", int'(blk_irq), 0);

    // R8 row 5 ends with status fetch
    cfg(0, 0, 0, 0, 0);
    go(); cyc(3); fin();
    cmp("R8 row5 end", int'(xfer_end), 1);
    cmp("R8 row5 status", int'(status_fetch), 1);
    ack();

    // R6 / R9 row 4 held until acknowledged
    cfg(1, 0, 1, 0, 1);
    go(); cyc(2);
    chan_go = 1; cyc(); chan_go = 0;
    cmp("R1 go ignored busy", int'(blk_go), 0);
    fin();
    cmp("R6 held", int'(blk_go), 0);
    cmp("R4 irq raised", int'(blk_irq), 1);
    for (int i = 0; i < 5; i++) begin
      cyc();
      cmp("R6 still held", int'(blk_go), 0);
    end
    ack();
    cmp("R6 released", int'(blk_go), 1);
    cmp("R2 both base", int'({src_sel, dst_sel}), 0);
    cyc(2); fin();
    cmp("R9 repeats", int'(xfer_end), 0);
    ack(); cyc();
    cfg(1, 0, 0, 0, 1);
    cyc(2); fin();
    cmp("R9 one reload left", int'(xfer_end), 0);
    cmp("R2 src runs on", int'(src_sel), 1);
    cmp("R2 dst base", int'(dst_sel), 0);
    ack(); cyc();
    cfg(1, 0, 0, 0, 0);
    cyc(); fin();
    cmp("R9 ends when cleared", int'(xfer_end), 1);
    ack();

    // R7 row 2 masked: no hold
    blk_mask = 1; cfg(1, 0, 1, 0, 0);
    go(); cyc(2); fin();
    cmp("R7 masked no hold", int'(blk_go), 1);
    cmp("R2 row2 sels", int'({src_sel, dst_sel}), 4'b0001);
    cmp("R4 masked no irq", int'(blk_irq), 0);
    cfg(1, 0, 0, 0, 0);
    cyc(); fin();
    cmp("R8 row1 after row2", int'(xfer_end), 1);

    // R7 row 3 interrupts disabled
    blk_mask = 0; irq_enable = 0; cfg(1, 0, 0, 0, 1);
    go(); cyc(); fin();
    cmp("R7 disabled no hold", int'(blk_go), 1);
    fin();
    cmp("R7 back to back", int'(blk_go), 1);
    cfg(1, 0, 0, 0, 0);
    fin();
    cmp("R8 row3 done", int'(xfer_end), 1);

    // R10 early acknowledgement
    irq_enable = 1; cfg(1, 0, 1, 0, 1);
    go(); cyc(); ack(); cyc();
    fin();
    cmp("R10 not yet", int'(blk_go), 0);
    cmp("R10 irq still raised", int'(blk_irq), 1);
    cyc();
    cmp("R10 released by kept ack", int'(blk_go), 1);
    cfg(1, 0, 0, 0, 0);
    cyc(); fin(); ack();

    // R5 rows 10 and 8
    cfg(0, 1, 0, 1, 0);
    go(); cyc(); fin();
    cmp("R5 fetch raised", int'(desc_fetch), 1);
    cmp("R5 no hold no go", int'(blk_go), 0);
    cyc(2);
    cmp("R5 fetch held", int'(desc_fetch), 1);
    dack();
    cmp("R5 go after ack", int'(blk_go), 1);
    cmp("R5 fetch dropped", int'(desc_fetch), 0);
    cmp("R2 both desc", int'({src_sel, dst_sel}), 4'b1010);
    ack();
    cfg(0, 1, 0, 0, 0);
    cyc(); fin();
    cmp("R5 row8 fetch", int'(desc_fetch), 1);
    cmp("R2 row8 sels", int'({src_sel, dst_sel}), 4'b1001);
    dack(); ack();
    cfg(0, 0, 0, 0, 0);
    fin();
    cmp("R8 list ends row5", int'(status_fetch), 1);
    ack();

    // R11 row 7: hold, then fetch
    cfg(0, 0, 1, 1, 0);
    go(); cyc(); fin();
    cmp("R11 held no fetch", int'(desc_fetch), 0);
    cyc(2);
    ack();
    cmp("R11 fetch after ack", int'(desc_fetch), 1);
    cmp("R11 no go yet", int'(blk_go), 0);
    dack();
    cmp("R11 go", int'(blk_go), 1);
    cmp("R2 row7 sels", int'({src_sel, dst_sel}), 4'b0010);
    cfg(1, 0, 0, 0, 0);
    cyc(); fin(); ack();

    // R3 unsupported configuration
    cfg(0, 0, 1, 0, 0);
    go();
    cmp("R3 fault at start", int'(cfg_fault), 1);
    cmp("R3 no block", int'(blk_go), 0);
    cyc();
    blk_mask = 1; cfg(1, 0, 1, 0, 0);
    go(); cyc();
    cfg(0, 0, 1, 0, 0);
    fin();
    cmp("R3 fault at end", int'(cfg_fault), 1);
    cmp("R3 ends", int'(xfer_end), 1);
    cmp("R3 no status", int'(status_fetch), 0);
    cyc(3);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule